// File: doc/BRIEF.md
# Banked Millisecond Reload Timer

This block is a small host-visible register file with four register banks and a 12-bit down-counting interval timer. A byte-wide host bus reads and writes eight offsets. Which register an offset reaches depends on a bank number. The bank number lives in a bank-select register that is visible at the same offset in every bank. Bank 1 holds a fixed version code and the two halves of the timer's reload value. Bank 0 holds the timer control register, which has an enable bit and a sticky expiry flag.

An external strobe, one clock wide and pulsed once per millisecond, drives the counter. When software sets the enable bit, the counter loads the programmed reload value. The counter then steps down by one on each strobe. Each time it runs out, it raises the expiry flag and reloads itself, so with a reload value of N the flag repeats every N milliseconds, up to 4095 ms. Software clears the flag by writing a one to it. The flag is also driven on a dedicated output pin.

Top module: `mstimer_bank`

## Requirements
- R1: In bank 1, offset 2 always reads 0x10, and writes to it have no effect.
- R2: Offset 3 is the bank-select register in every bank. Bits 7:6 hold the bank number (0 to 3) and reset to 0. Bits 5:0 read 0. Reading offset 3 gives the same value whatever bank is selected.
- R3: In bank 1, offset 4 is read/write. It holds reload bits 7:0 and resets to 0x00.
- R4: In bank 1, offset 5 bits 3:0 hold reload bits 11:8, and the register resets to 0x00. Bits 7:4 read 0 and ignore writes.
- R5: A bank 0 offset 2 write that takes bit 0 (enable) from 0 to 1 loads the reload value N, where N is from 1 to 4095. The flag then sets on the Nth enabled tick, and again every N ticks after that, because the counter reloads itself.
- R6: Ticks while enable is 0 do not advance the counter. Clearing enable freezes the count. Setting it again restarts a full interval of N.
- R7: The flag is bit 1 of bank 0 offset 2 and resets to 0. It stays set until a write of 1 to that bit clears it. Writing 0 to bit 1 leaves the flag unchanged.
- R8: A reload value of 0 keeps the counter idle, and the flag never sets.
- R9: Offsets 0, 1, 6 and 7 read 0 in every bank, and writes to them have no effect. Bits 7:2 of bank 0 offset 2 read 0.
- R10: Offsets 4 and 5 hold reload data only in bank 1. Writes to them in any other bank leave the reload value unchanged.
- R11: If expiry and a clear write fall on the same clock edge, the flag ends up set.
- R12: Output `tmr_flag` always equals the flag bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, taken at the rising clock edge |
| wr_data | input | 8 | Write data |
| tick_ms | input | 1 | One-clock strobe per millisecond |
| rd_data | output | 8 | Read data for `addr` in the current bank (combinational) |
| tmr_flag | output | 1 | Sticky timer expiry flag |

## Verification
Read data is combinational from the register state. A register written at one rising edge is therefore sampled on `rd_data` at the next falling edge. The flag changes at the same edge that takes the final tick or the clearing write, and the bench checks `tmr_flag` and offset 2 half a cycle after that edge. Every stimulus is driven at a falling edge and held for exactly one rising edge. The bench model advances once per bus step, so expected values and design outputs stay aligned cycle for cycle, including the cases where a tick and a write share an edge.

// File: rtl/mstimer_pkg.sv
package mstimer_pkg;
   localparam int BUS_W  = 8;
   localparam int ADDR_W = 3;
   localparam int BANK_W = 2;
   localparam int BSEL_LSB = BUS_W - BANK_W;

   localparam logic [ADDR_W-1:0] OFF_TCTL = 3'd2;
   localparam logic [ADDR_W-1:0] OFF_VER  = 3'd2;
   localparam logic [ADDR_W-1:0] OFF_BSEL = 3'd3;
   localparam logic [ADDR_W-1:0] OFF_RLO  = 3'd4;
   localparam logic [ADDR_W-1:0] OFF_RHI  = 3'd5;

   typedef enum logic [BANK_W-1:0] {
      BANK_TMR = 2'd0,
      BANK_CFG = 2'd1,
      BANK_AUX2 = 2'd2,
      BANK_AUX3 = 2'd3
   } bank_e;

   localparam int TCTL_EN_BIT   = 0;
   localparam int TCTL_FLAG_BIT = 1;
endpackage

// File: rtl/mstimer_regs.sv
module mstimer_regs
   import mstimer_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter logic [BUS_W-1:0] VERSION = 8'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              flag_i,
   output logic [BUS_W-1:0]  rd_data,
   output logic [BANK_W-1:0] bank_o,
   output logic              en_o,
   output logic              load_o,
   output logic              clr_o,
   output logic [CNT_W-1:0]  reload_o
);
   localparam int HI_W = CNT_W - BUS_W;

   bank_e             bank_q;
   logic              en_q;
   logic [BUS_W-1:0]  rlo_q;
   logic [HI_W-1:0]   rhi_q;
   logic [BUS_W-1:0]  rhi_rd;

   logic wr_bsel, wr_tctl, wr_rlo, wr_rhi;

   assign wr_bsel = wr_en && (addr == OFF_BSEL);
   assign wr_tctl = wr_en && (bank_q == BANK_TMR) && (addr == OFF_TCTL);
   assign wr_rlo  = wr_en && (bank_q == BANK_CFG) && (addr == OFF_RLO);
   assign wr_rhi  = wr_en && (bank_q == BANK_CFG) && (addr == OFF_RHI);

   assign load_o = wr_tctl && wr_data[TCTL_EN_BIT] && !en_q;
   assign clr_o  = wr_tctl && wr_data[TCTL_FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= BANK_TMR;
         en_q   <= 1'b0;
         rlo_q  <= '0;
         rhi_q  <= '0;
      end else begin
         if (wr_bsel) bank_q <= bank_e'(wr_data[BUS_W-1:BSEL_LSB]);
         if (wr_tctl) en_q   <= wr_data[TCTL_EN_BIT];
         if (wr_rlo)  rlo_q  <= wr_data;
         if (wr_rhi)  rhi_q  <= wr_data[HI_W-1:0];
      end
   end

   generate
      if (HI_W == BUS_W) begin : g_hi_full
         assign rhi_rd = rhi_q;
      end else begin : g_hi_pad
         assign rhi_rd = {{(BUS_W-HI_W){1'b0}}, rhi_q};
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (addr == OFF_BSEL) begin
         rd_data[BUS_W-1:BSEL_LSB] = bank_q;
      end else begin
         unique case (bank_q)
            BANK_TMR: begin
               if (addr == OFF_TCTL) begin
                  rd_data[TCTL_EN_BIT]   = en_q;
                  rd_data[TCTL_FLAG_BIT] = flag_i;
               end
            end
            BANK_CFG: begin
               if (addr == OFF_VER)      rd_data = VERSION;
               else if (addr == OFF_RLO) rd_data = rlo_q;
               else if (addr == OFF_RHI) rd_data = rhi_rd;
            end
            default: rd_data = '0;
         endcase
      end
   end

   assign bank_o   = bank_q;
   assign en_o     = en_q;
   assign reload_o = {rhi_q, rlo_q};
endmodule

// File: rtl/mstimer_count.sv
module mstimer_count #(
   parameter int CNT_W    = 12,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             load,
   input  logic             clr,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt_o,
   output logic             flag_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             flag_q, flag_d;
   logic             step, expire;

   assign step   = en && tick && !load;
   assign expire = step && (cnt_q == ONE);

   always_comb begin
      cnt_d = cnt_q;
      if (load)
         cnt_d = reload;
      else if (step)
         cnt_d = (cnt_q <= ONE) ? reload : cnt_q - ONE;
   end

   generate
      if (SET_WINS) begin : g_set_first
         assign flag_d = expire ? 1'b1 : (clr ? 1'b0 : flag_q);
      end else begin : g_clr_first
         assign flag_d = clr ? 1'b0 : (expire ? 1'b1 : flag_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         flag_q <= flag_d;
      end
   end

   assign cnt_o  = cnt_q;
   assign flag_o = flag_q;
endmodule

// File: rtl/mstimer_bank.sv
module mstimer_bank
   import mstimer_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter logic [BUS_W-1:0] VERSION = 8'h10,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              tick_ms,
   output logic [BUS_W-1:0]  rd_data,
   output logic              tmr_flag
);
   generate
      if (CNT_W <= BUS_W || CNT_W > 2*BUS_W) begin : g_bad_width
         $error("mstimer_bank: CNT_W must be in 9..16");
      end
   endgenerate

   logic              en_w, load_w, clr_w, flag_w;
   logic [BANK_W-1:0] bank_w;
   logic [CNT_W-1:0]  reload_w, cnt_w;

   mstimer_regs #(.CNT_W(CNT_W), .VERSION(VERSION)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .flag_i   (flag_w),
      .rd_data  (rd_data),
      .bank_o   (bank_w),
      .en_o     (en_w),
      .load_o   (load_w),
      .clr_o    (clr_w),
      .reload_o (reload_w)
   );

   mstimer_count #(.CNT_W(CNT_W), .SET_WINS(SET_WINS)) i_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_ms),
      .en     (en_w),
      .load   (load_w),
      .clr    (clr_w),
      .reload (reload_w),
      .cnt_o  (cnt_w),
      .flag_o (flag_w)
   );

   assign tmr_flag = flag_w;
endmodule

// File: rtl/mstimer_chk.sv
module mstimer_chk #(
   parameter int CNT_W = 12,
   parameter logic [7:0] VERSION = 8'h10
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       addr,
   input logic             wr_en,
   input logic [7:0]       wr_data,
   input logic             tick_ms,
   input logic [7:0]       rd_data,
   input logic             tmr_flag,
   input logic [1:0]       bank,
   input logic             en,
   input logic [CNT_W-1:0] cnt
);
   p_version_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bank == 2'd1 && addr == 3'd2) |-> rd_data == VERSION);

   p_bsel_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 3'd3) |-> (rd_data[5:0] == 6'd0 && rd_data[7:6] == bank));

   p_hold_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wr_en) |=> $stable(cnt));

   p_flag_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_flag) |-> $past(en && tick_ms));

   p_flag_at_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_flag) |-> $past(cnt) == CNT_W'(1));

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bank == 2'd0 && addr == 3'd2 && wr_data[1] && !tick_ms) |=> !tmr_flag);

   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick_ms && cnt == CNT_W'(1) && !wr_en) |=> tmr_flag);

   p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (addr <= 3'd1 || addr >= 3'd6) |-> rd_data == 8'h00);
endmodule

bind mstimer_bank mstimer_chk #(.CNT_W(CNT_W), .VERSION(VERSION)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .tick_ms  (tick_ms),
   .rd_data  (rd_data),
   .tmr_flag (tmr_flag),
   .bank     (bank_w),
   .en       (en_w),
   .cnt      (cnt_w)
);

// File: tb/test_mstimer_bank.sv
module test_mstimer_bank;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] addr;
   logic       wr_en;
   logic [7:0] wr_data;
   logic       tick_ms;
   logic [7:0] rd_data;
   logic       tmr_flag;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   logic [1:0]  m_bank;
   logic        m_en, m_flag;
   logic [11:0] m_cnt, m_rel;

   always #10 clk = ~clk;

   mstimer_bank i_mstimer_bank (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .tick_ms(tick_ms), .rd_data(rd_data), .tmr_flag(tmr_flag)
   );

   function automatic logic [7:0] exp_rd(input logic [2:0] a);
      if (a == 3'd3) return {m_bank, 6'd0};
      if (m_bank == 2'd0 && a == 3'd2) return {6'd0, m_flag, m_en};
      if (m_bank == 2'd1) begin
         if (a == 3'd2) return 8'h10;
         if (a == 3'd4) return m_rel[7:0];
         if (a == 3'd5) return {4'd0, m_rel[11:8]};
      end
      return 8'h00;
   endfunction

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic step(input bit we, input logic [2:0] a, input logic [7:0] d, input bit tk);
      logic [1:0] ob;
      logic hit, ld, cl, st;
      ob  = m_bank;
      hit = we && ob == 2'd0 && a == 3'd2;
      ld  = hit && d[0] && !m_en;
      cl  = hit && d[1];
      st  = m_en && tk && !ld && m_cnt == 12'd1;
      m_flag = st ? 1'b1 : (cl ? 1'b0 : m_flag);
      if (ld) m_cnt = m_rel;
      else if (m_en && tk) m_cnt = (m_cnt <= 12'd1) ? m_rel : m_cnt - 12'd1;
      if (we) begin
         if (a == 3'd3) m_bank = d[7:6];
         if (hit) m_en = d[0];
         if (ob == 2'd1 && a == 3'd4) m_rel[7:0] = d;
         if (ob == 2'd1 && a == 3'd5) m_rel[11:8] = d[3:0];
      end
      @(negedge clk);
      addr = a; wr_en = we; wr_data = d; tick_ms = tk;
      @(posedge clk);
      #1;
      wr_en = 1'b0; tick_ms = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      step(1'b1, a, d, 1'b0);
   endtask

   task automatic sel(input logic [1:0] b);
      wr(3'd3, {b, 6'd0});
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, 8'h00, 1'b1);
   endtask

   task automatic rdchk(input logic [2:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      addr = a;
      #1;
      check(req, rd_data, exp);
   endtask

   task automatic flagchk(input logic exp, input string req);
      @(negedge clk);
      check(req, {7'd0, tmr_flag}, {7'd0, exp});
   endtask

   task automatic set_reload(input logic [11:0] v);
      sel(2'd1);
      wr(3'd4, v[7:0]);
      wr(3'd5, {4'd0, v[11:8]});
      sel(2'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int r;
      void'($urandom(20240607));
      rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0; tick_ms = 1'b0;
      m_bank = 2'd0; m_en = 1'b0; m_flag = 1'b0; m_cnt = '0; m_rel = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state: R2, R7, R12
      rdchk(3'd3, 8'h00, "R2 reset bank");
      rdchk(3'd2, 8'h00, "R7 reset control");
      flagchk(1'b0, "R12 reset pin");

      // bank select and version: R1, R2
      sel(2'd1);
      rdchk(3'd3, 8'h40, "R2 bank1 select");
      rdchk(3'd2, 8'h10, "R1 version");
      wr(3'd2, 8'hFF);
      rdchk(3'd2, 8'h10, "R1 version write ignored");
      // reload reset values: R3, R4
      rdchk(3'd4, 8'h00, "R3 reset low");
      rdchk(3'd5, 8'h00, "R4 reset high");
      wr(3'd4, 8'hA5);
      wr(3'd5, 8'hFB);
      rdchk(3'd4, 8'hA5, "R3 low byte");
      rdchk(3'd5, 8'h0B, "R4 high nibble reserved bits");
      sel(2'd2);
      rdchk(3'd3, 8'h80, "R2 bank2 select");
      wr(3'd3, 8'hFF);
      rdchk(3'd3, 8'hC0, "R2 low bits zero");

      // bank-qualified reload: R10
      sel(2'd0);
      wr(3'd4, 8'h33);
      wr(3'd5, 8'h07);
      sel(2'd3);
      wr(3'd4, 8'h44);
      sel(2'd1);
      rdchk(3'd4, 8'hA5, "R10 low byte kept");
      rdchk(3'd5, 8'h0B, "R10 high nibble kept");

      // unimplemented offsets: R9
      for (int b = 0; b < 4; b++) begin
         sel(2'(b));
         for (int a = 0; a < 8; a++) begin
            if (a <= 1 || a >= 6) begin
               wr(3'(a), 8'hFF);
               rdchk(3'(a), 8'h00, "R9 unimplemented offset");
            end
         end
      end
      sel(2'd0);
      wr(3'd2, 8'hFC);
      rdchk(3'd2, 8'h00, "R9 control high bits");

      // interval and auto reload: R5, R7, R12
      set_reload(12'd3);
      wr(3'd2, 8'h01);
      ticks(2);
      flagchk(1'b0, "R5 before terminal count");
      ticks(1);
      flagchk(1'b1, "R5 terminal count");
      rdchk(3'd2, 8'h03, "R12 flag bit matches pin");
      wr(3'd2, 8'h01);
      rdchk(3'd2, 8'h03, "R7 write zero keeps flag");
      wr(3'd2, 8'h03);
      rdchk(3'd2, 8'h01, "R7 clear by one");
      ticks(2);
      flagchk(1'b0, "R5 reload mid interval");
      ticks(1);
      flagchk(1'b1, "R5 auto reload period");

      // disable freezes, re-enable restarts: R6
      wr(3'd2, 8'h02);
      ticks(10);
      flagchk(1'b0, "R6 no count while off");
      wr(3'd2, 8'h01);
      ticks(2);
      wr(3'd2, 8'h00);
      ticks(5);
      flagchk(1'b0, "R6 frozen count");
      wr(3'd2, 8'h01);
      ticks(2);
      flagchk(1'b0, "R6 restart full interval");
      ticks(1);
      flagchk(1'b1, "R6 restart expiry");

      // zero reload idle: R8
      wr(3'd2, 8'h02);
      set_reload(12'd0);
      wr(3'd2, 8'h01);
      ticks(50);
      flagchk(1'b0, "R8 zero reload idle");

      // set beats clear: R11
      wr(3'd2, 8'h02);
      set_reload(12'd2);
      wr(3'd2, 8'h01);
      ticks(1);
      step(1'b1, 3'd2, 8'h03, 1'b1);
      flagchk(1'b1, "R11 set wins over clear");

      // maximum interval: R5
      wr(3'd2, 8'h02);
      set_reload(12'hFFF);
      wr(3'd2, 8'h01);
      ticks(4094);
      flagchk(1'b0, "R5 max minus one");
      ticks(1);
      flagchk(1'b1, "R5 max interval 4095");

      // random mix against the model: R5 R6 R7 R12
      for (int i = 0; i < 600; i++) begin
         r = int'($urandom % 10);
         case (r)
            0, 1, 2, 3, 4: ticks(1 + int'($urandom % 4));
            5: begin sel(2'd1); wr(3'd4, 8'($urandom % 12)); end
            6: begin sel(2'd1); wr(3'd5, ($urandom % 4 == 0) ? 8'($urandom) : 8'h00); end
            7: begin sel(2'd0); wr(3'd2, {6'd0, 1'b0, 1'($urandom)}); end
            8: begin sel(2'd0); wr(3'd2, {6'd0, 1'b1, m_en}); end
            default: sel(2'($urandom));
         endcase
         flagchk(m_flag, "R12 random flag pin");
         r = int'($urandom % 8);
         rdchk(3'(r), exp_rd(3'(r)), "R5 random readback");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule